// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words, A and B, and reports which relation holds: A above B, A equal to B, or A below B. It is built from identical 4-bit slices. Each slice scans its own bits from the top bit down, and the first bit where A and B differ settles the outcome. When all four of its own bit pairs match, the slice hands on the verdict it receives from the slice below it through three cascade inputs.

The top module chains `WIDTH/4` slices, with the least significant slice at the bottom of the chain. The cascade inputs of that bottom slice are tied to "equal". The result comes from the most significant slice. There is no clock and no storage. The outputs follow the operands combinationally, so the block can sit in any datapath that needs an unsigned ordering test.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is larger than `b_i`, with both read as unsigned numbers.
- R2: `lt_o` is 1 exactly when `a_i` is smaller than `b_i`, with both read as unsigned numbers.
- R3: `eq_o` is 1 only when every bit of `a_i` matches the bit of `b_i` at the same position.
- R4: Exactly one of `gt_o`, `eq_o` and `lt_o` is 1 for every operand pair.
- R5: The highest bit position where the operands differ decides the result. Differences at lower positions have no effect; for example, A=0x80 against B=0x7F gives `gt_o`=1.
- R6: A slice whose own four bit pairs all match copies its three cascade inputs to its outputs. At the top level this means that when the upper nibbles are equal, the lower nibble decides the result.
- R7: The cascade inputs of the least significant slice are fixed at equal=1, greater=0 and less=0, so fully equal operands give `eq_o`=1.
- R8: `WIDTH` defaults to 8, must be a multiple of 4, and builds a chain of `WIDTH/4` identical slices.
- R9: The outputs are purely combinational. They take on the correct value for new operands with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| gt_o | output | 1 | A is larger than B |
| eq_o | output | 1 | A equals B |
| lt_o | output | 1 | A is smaller than B |

## Verification
The bench targets pairs where the upper nibbles differ one way and the lower nibbles differ the other way. A slice that let a lower bit override a higher one would flip the answer on these pairs. It also targets pairs whose upper nibbles match, where a broken cascade path in the upper slice would lose the lower slice's verdict or report equality. Pairs that differ only in bit 0, and the extreme values 0x00 and 0xFF, catch a wrong tie-off at the bottom of the chain or a dropped edge bit. An exhaustive sweep and a random pass also check that exactly one output is high, which catches outputs that overlap or all go low.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_res_t;

  localparam cmp_res_t RES_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/mag_cmp_bit.sv
module mag_cmp_bit (
  input  logic a_i,
  input  logic b_i,
  output logic gt_o,
  output logic eq_o,
  output logic lt_o
);
  assign gt_o = a_i & ~b_i;
  assign lt_o = ~a_i & b_i;
  assign eq_o = ~(a_i ^ b_i);
endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_res_t     casc_i,
  output cmp_res_t     res_o
);
  logic [W-1:0] bit_gt, bit_eq, bit_lt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    mag_cmp_bit u_bit (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .gt_o (bit_gt[i]),
      .eq_o (bit_eq[i]),
      .lt_o (bit_lt[i])
    );
  end

  always_comb begin
    logic decided;
    decided = 1'b0;
    res_o   = casc_i;
    // top bit first; the first mismatch locks the verdict
    for (int i = W - 1; i >= 0; i--) begin
      if (!decided && !bit_eq[i]) begin
        decided  = 1'b1;
        res_o.gt = bit_gt[i];
        res_o.lt = bit_lt[i];
        res_o.eq = 1'b0;
      end
    end

    p_gt_own_r1: assert (!(a_i > b_i) || (res_o.gt && !res_o.lt && !res_o.eq));
    p_lt_own_r2: assert (!(a_i < b_i) || (res_o.lt && !res_o.gt && !res_o.eq));
    p_pass_through_r6: assert ((a_i != b_i) || (res_o == casc_i));
    p_one_hot_r4: assert (!$onehot({casc_i.gt, casc_i.eq, casc_i.lt})
                          || $onehot({res_o.gt, res_o.eq, res_o.lt}));
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);
  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  if ((WIDTH % SLICE_W) != 0 || WIDTH == 0) begin : g_bad_width
    $error("mag_cmp_chain: WIDTH must be a nonzero multiple of 4 (R8)");
  end

  cmp_res_t link [NSLICE+1];

  assign link[0] = RES_EQUAL; // R7 tie-off of the bottom slice

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    mag_cmp_slice #(.W(SLICE_W)) u_slice (
      .a_i    (a_i[s*SLICE_W +: SLICE_W]),
      .b_i    (b_i[s*SLICE_W +: SLICE_W]),
      .casc_i (link[s]),
      .res_o  (link[s+1])
    );
  end

  assign gt_o = link[NSLICE].gt;
  assign eq_o = link[NSLICE].eq;
  assign lt_o = link[NSLICE].lt;
endmodule

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic gt, eq, lt;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  mag_cmp_chain #(.WIDTH(W)) u_mag_cmp_chain (
    .a_i(a), .b_i(b), .gt_o(gt), .eq_o(eq), .lt_o(lt)
  );

  task automatic check_pair(input logic [W-1:0] xa, input logic [W-1:0] xb,
                            input string req);
    logic [2:0] exp, got;
    @(negedge clk);
    a = xa;
    b = xb;
    #1;
    exp = {xa > xb, xa == xb, xa < xb};
    got = {gt, eq, lt};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h got gt/eq/lt=%b expected %b", req, xa, xb, got, exp);
    end
    n_chk++;
    if ($countones(got) != 1) begin
      n_bad++;
      $display("FAIL R4 a=%h b=%h got gt/eq/lt=%b expected one-hot", xa, xb, got);
    end
  endtask

  task automatic t_reset_state;
    check_pair('0, '0, "R7 zero operands");
  endtask

  task automatic t_msb_priority;
    check_pair(8'h80, 8'h7F, "R5 top bit wins");
    check_pair(8'h7F, 8'h80, "R5 top bit wins");
    check_pair(8'h10, 8'h0F, "R5 upper nibble beats lower");
    check_pair(8'h2F, 8'h30, "R5 upper nibble beats lower");
  endtask

  task automatic t_cascade;
    check_pair(8'hA5, 8'hA4, "R6 low nibble decides");
    check_pair(8'h3C, 8'h3D, "R6 low nibble decides");
    check_pair(8'hFE, 8'hFF, "R6 bit0 only");
    check_pair(8'h5A, 8'h5A, "R3 R7 all equal");
  endtask

  task automatic t_extremes;
    check_pair(8'hFF, 8'h00, "R1 extreme");
    check_pair(8'h00, 8'hFF, "R2 extreme");
    check_pair(8'hFF, 8'hFF, "R3 extreme");
  endtask

  task automatic t_exhaustive;
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        check_pair(i[W-1:0], j[W-1:0], "R1 R2 R3 R8 sweep");
  endtask

  task automatic t_random;
    for (int k = 0; k < 2000; k++)
      check_pair(W'($urandom), W'($urandom), "R9 random");
  endtask

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_msb_priority();
    t_cascade();
    t_extremes();
    t_exhaustive();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule